// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This block follows one core's hardware memory transaction and decides whether it ends in a commit or an abort. While a transaction runs, every local load or store is looked up by cache-line address in a small fully associative table. Each entry records whether the line has been read and whether it has been written. Stores are not sent to memory. They wait in a local buffer, in issue order. Remote snoops, each a line address with a read or write type, are compared against the table under asymmetric rules. A line that has only been read survives remote reads but not remote writes. A line that has been written survives no remote access at all. Eviction notices from the cache also end the transaction if they name a tracked line, as does running out of table entries or buffer slots.

A begin issued inside a running transaction only deepens the nesting, and only the end that brings the depth back to zero commits. On commit the buffered stores are written out to the memory port one per cycle, oldest first. The transaction stays active until the last one has left, and then the table is cleared. On abort, whatever the cause or the depth, the buffer and table are emptied at once, nothing reaches memory, and one abort pulse carries a cause code.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset, tx_active, commit_pulse, abort_pulse and mem_wr_valid are all low.
- R2: tx_begin while idle makes tx_active high on the next cycle. A tx_begin while running only increments the depth, and only the tx_end that brings the depth to zero commits, with commit_pulse high for the one cycle after that tx_end is sampled. An inner tx_end produces no pulse and no memory write.
- R3: A remote read snoop (snp_is_write = 0) to a line that has only been loaded in the current transaction does not abort it.
- R4: A remote write snoop (snp_is_write = 1) to a line that has been loaded in the current transaction aborts it: abort_pulse is high for the cycle after the snoop, with abort_cause = 1, and tx_active is low in that same cycle.
- R5: A remote read or write snoop to a line that has been stored in the current transaction aborts it, with abort_cause = 1.
- R6: Conflicts are compared on the line address only, which is addr[ADDR_W-1:OFS_W] (with OFS_W = 2, four words per line). Different words of one line conflict, and words of different lines do not.
- R7: Buffered stores never appear on the memory port before commit. After commit they appear in issue order, one per cycle, the first in the same cycle as commit_pulse. tx_active stays high through the last write and is low in the cycle after it.
- R8: On any abort, no buffered store ever appears on the memory port (mem_wr_valid stays low).
- R9: An eviction notice for a tracked line aborts the running transaction with abort_cause = 2. An eviction notice for an untracked line has no effect.
- R10: A load or store to a new line when all NUM_LINES entries are in use, or a store when SB_DEPTH stores are already buffered, aborts the transaction with abort_cause = 2.
- R11: A tx_begin at depth MAX_NEST aborts with abort_cause = 3. After any abort the depth is zero, so after a new tx_begin a single tx_end commits.
- R12: tx_abort_req while running aborts with abort_cause = 0. This cause wins over a conflicting snoop in the same cycle, and only one abort pulse is produced for the transaction.
- R13: After a commit has drained, the read and write marks are cleared, so a later transaction is not aborted by a remote write to a line that only the earlier transaction touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Transaction begin strobe (nests while running) |
| tx_end | input | 1 | Transaction end strobe |
| tx_abort_req | input | 1 | Explicit abort request |
| ld_valid | input | 1 | Local load request |
| ld_addr | input | ADDR_W | Load word address |
| st_valid | input | 1 | Local store request (wins over a same-cycle load) |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| snp_valid | input | 1 | Remote snoop request |
| snp_addr | input | ADDR_W | Snoop word address |
| snp_is_write | input | 1 | Snoop type: 1 write, 0 read |
| evict_valid | input | 1 | Eviction notice |
| evict_addr | input | ADDR_W | Evicted word address |
| commit_pulse | output | 1 | One-cycle commit indication |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_cause | output | 2 | 0 explicit, 1 conflict, 2 capacity or eviction, 3 nesting overflow |
| mem_wr_valid | output | 1 | Drained store valid |
| mem_wr_addr | output | ADDR_W | Drained store address |
| mem_wr_data | output | DATA_W | Drained store data |
| tx_active | output | 1 | Transaction running or draining |

## Verification
The hardest case to reach is an explicit abort and a conflicting remote write that land on a written line in the same cycle. The cause code must show the explicit request, there must be only one pulse, and nothing may drain. The bench first stores to a line and then raises both inputs in one cycle. Resource limits are reached the same way, by filling every table entry and then every buffer slot before the access that overflows. The asymmetric snoop rules and line-granularity rules come from a table of load or store plus snoop scenarios. Each uses addresses that fall in the same line or in neighbouring lines.

// File: rtl/tct_pkg.sv
package tct_pkg;
   typedef enum logic [1:0] {
      CAUSE_EXPLICIT = 2'd0,
      CAUSE_CONFLICT = 2'd1,
      CAUSE_CAPACITY = 2'd2,
      CAUSE_NEST     = 2'd3
   } abort_cause_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } tx_state_e;
endpackage

// File: rtl/tct_line_table.sv
module tct_line_table #(
   parameter int LINE_W    = 10,
   parameter int NUM_LINES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              acc_req_i,
   input  logic              upd_en_i,
   input  logic [LINE_W-1:0] acc_line_i,
   input  logic              acc_store_i,
   input  logic              snp_valid_i,
   input  logic [LINE_W-1:0] snp_line_i,
   input  logic              snp_write_i,
   input  logic              ev_valid_i,
   input  logic [LINE_W-1:0] ev_line_i,
   output logic              conflict_o,
   output logic              evict_hit_o,
   output logic              no_room_o
);
   localparam int IDX_W = $clog2(NUM_LINES);

   logic [NUM_LINES-1:0] vld_q, rd_q, wr_q;
   logic [LINE_W-1:0]    tag_q [NUM_LINES];
   logic [NUM_LINES-1:0] acc_hit, snp_hit, ev_hit;
   logic [IDX_W-1:0]     free_idx;
   logic                 have_free, acc_hit_any;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
      assign acc_hit[g] = vld_q[g] && (tag_q[g] == acc_line_i);
      assign snp_hit[g] = vld_q[g] && (tag_q[g] == snp_line_i);
      assign ev_hit[g]  = vld_q[g] && (tag_q[g] == ev_line_i);
   end

   always_comb begin
      free_idx  = '0;
      have_free = 1'b0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            free_idx  = IDX_W'(i);
            have_free = 1'b1;
         end
      end
   end

   assign acc_hit_any = |acc_hit;
   assign no_room_o   = acc_req_i && !acc_hit_any && !have_free;
   assign evict_hit_o = ev_valid_i && (|ev_hit);
   assign conflict_o  = snp_valid_i &&
                        (|(snp_hit & (wr_q | ({NUM_LINES{snp_write_i}} & rd_q))));

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         vld_q <= '0;
         rd_q  <= '0;
         wr_q  <= '0;
         for (int i = 0; i < NUM_LINES; i++) tag_q[i] <= '0;
      end else if (upd_en_i) begin
         if (acc_hit_any) begin
            for (int i = 0; i < NUM_LINES; i++) begin
               if (acc_hit[i]) begin
                  if (acc_store_i) wr_q[i] <= 1'b1;
                  else             rd_q[i] <= 1'b1;
               end
            end
         end else if (have_free) begin
            vld_q[free_idx] <= 1'b1;
            tag_q[free_idx] <= acc_line_i;
            wr_q[free_idx]  <= acc_store_i;
            rd_q[free_idx]  <= !acc_store_i;
         end
      end
   end
endmodule

// File: rtl/tct_store_buf.sv
module tct_store_buf #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 16,
   parameter int SB_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic              full_o,
   output logic              empty_o,
   output logic              last_o,
   output logic [ADDR_W-1:0] head_addr_o,
   output logic [DATA_W-1:0] head_data_o
);
   localparam int CNT_W = $clog2(SB_DEPTH + 1);
   localparam int IDX_W = $clog2(SB_DEPTH);

   logic [ADDR_W-1:0] addr_q [SB_DEPTH];
   logic [DATA_W-1:0] data_q [SB_DEPTH];
   logic [CNT_W-1:0]  wr_ptr_q, rd_ptr_q;

   assign full_o      = (wr_ptr_q == CNT_W'(SB_DEPTH));
   assign empty_o     = (wr_ptr_q == rd_ptr_q);
   assign last_o      = ((rd_ptr_q + CNT_W'(1)) == wr_ptr_q);
   assign head_addr_o = addr_q[rd_ptr_q[IDX_W-1:0]];
   assign head_data_o = data_q[rd_ptr_q[IDX_W-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
      end else begin
         if (push_i && !full_o) begin
            addr_q[wr_ptr_q[IDX_W-1:0]] <= push_addr_i;
            data_q[wr_ptr_q[IDX_W-1:0]] <= push_data_i;
            wr_ptr_q <= wr_ptr_q + CNT_W'(1);
         end
         if (pop_i && !empty_o) rd_ptr_q <= rd_ptr_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker
   import tct_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int OFS_W     = 2,
   parameter int DATA_W    = 16,
   parameter int NUM_LINES = 4,
   parameter int SB_DEPTH  = 4,
   parameter int MAX_NEST  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_begin,
   input  logic              tx_end,
   input  logic              tx_abort_req,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              snp_is_write,
   input  logic              evict_valid,
   input  logic [ADDR_W-1:0] evict_addr,
   output logic              commit_pulse,
   output logic              abort_pulse,
   output logic [1:0]        abort_cause,
   output logic              mem_wr_valid,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              tx_active
);
   localparam int LINE_W  = ADDR_W - OFS_W;
   localparam int DEPTH_W = $clog2(MAX_NEST + 1);

   if (NUM_LINES < 2) begin : g_bad_lines
      $error("NUM_LINES must be at least 2");
   end
   if (SB_DEPTH < 2) begin : g_bad_depth
      $error("SB_DEPTH must be at least 2");
   end
   if (OFS_W < 0 || OFS_W >= ADDR_W) begin : g_bad_ofs
      $error("OFS_W must leave at least one line address bit");
   end
   if (MAX_NEST < 1) begin : g_bad_nest
      $error("MAX_NEST must be at least 1");
   end

   tx_state_e        state_q;
   logic [DEPTH_W-1:0] depth_q;
   logic             run, drain;
   logic             acc_req, abort_now, commit_now, tbl_clear, sb_clear;
   logic             ab_expl, ab_nest, ab_conf, ab_cap;
   logic [ADDR_W-1:0] acc_addr;
   logic             lt_conflict, lt_evict, lt_no_room;
   logic             sb_full, sb_empty, sb_last;
   abort_cause_e     cause_now;

   assign run      = (state_q == ST_RUN);
   assign drain    = (state_q == ST_DRAIN);
   assign acc_req  = run && (st_valid || ld_valid);
   assign acc_addr = st_valid ? st_addr : ld_addr;

   assign ab_expl = run && tx_abort_req;
   assign ab_nest = run && tx_begin && (depth_q == DEPTH_W'(MAX_NEST));
   assign ab_conf = run && lt_conflict;
   assign ab_cap  = run && (lt_evict || lt_no_room || (st_valid && sb_full));
   assign abort_now  = ab_expl || ab_nest || ab_conf || ab_cap;
   assign commit_now = run && !abort_now && tx_end && (depth_q == DEPTH_W'(1));

   always_comb begin
      if (ab_expl)      cause_now = CAUSE_EXPLICIT;
      else if (ab_nest) cause_now = CAUSE_NEST;
      else if (ab_conf) cause_now = CAUSE_CONFLICT;
      else              cause_now = CAUSE_CAPACITY;
   end

   assign sb_clear  = abort_now || (drain && sb_last);
   assign tbl_clear = sb_clear || (commit_now && sb_empty);

   tct_line_table #(.LINE_W(LINE_W), .NUM_LINES(NUM_LINES)) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (tbl_clear),
      .acc_req_i   (acc_req),
      .upd_en_i    (acc_req && !abort_now),
      .acc_line_i  (acc_addr[ADDR_W-1:OFS_W]),
      .acc_store_i (st_valid),
      .snp_valid_i (snp_valid),
      .snp_line_i  (snp_addr[ADDR_W-1:OFS_W]),
      .snp_write_i (snp_is_write),
      .ev_valid_i  (evict_valid),
      .ev_line_i   (evict_addr[ADDR_W-1:OFS_W]),
      .conflict_o  (lt_conflict),
      .evict_hit_o (lt_evict),
      .no_room_o   (lt_no_room)
   );

   tct_store_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SB_DEPTH(SB_DEPTH)) u_sbuf (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (sb_clear),
      .push_i      (run && st_valid && !abort_now),
      .push_addr_i (st_addr),
      .push_data_i (st_data),
      .pop_i       (drain),
      .full_o      (sb_full),
      .empty_o     (sb_empty),
      .last_o      (sb_last),
      .head_addr_o (mem_wr_addr),
      .head_data_o (mem_wr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         depth_q      <= '0;
         commit_pulse <= 1'b0;
         abort_pulse  <= 1'b0;
         abort_cause  <= 2'd0;
      end else begin
         commit_pulse <= commit_now;
         abort_pulse  <= abort_now;
         if (abort_now) abort_cause <= cause_now;
         unique case (state_q)
            ST_IDLE: if (tx_begin) begin
               state_q <= ST_RUN;
               depth_q <= DEPTH_W'(1);
            end
            ST_RUN: begin
               if (abort_now) begin
                  state_q <= ST_IDLE;
                  depth_q <= '0;
               end else if (commit_now) begin
                  state_q <= sb_empty ? ST_IDLE : ST_DRAIN;
                  depth_q <= '0;
               end else if (tx_begin) begin
                  depth_q <= depth_q + DEPTH_W'(1);
               end else if (tx_end) begin
                  depth_q <= depth_q - DEPTH_W'(1);
               end
            end
            ST_DRAIN: if (sb_last) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_wr_valid = drain;
   assign tx_active    = (state_q != ST_IDLE);
endmodule

// File: rtl/tct_checker.sv
module tct_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_abort_req,
   input logic       in_run,
   input logic       commit_pulse,
   input logic       abort_pulse,
   input logic [1:0] abort_cause,
   input logic       mem_wr_valid,
   input logic       tx_active
);
   AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_pulse && abort_pulse)); // R2

   AST_DRAIN_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> tx_active); // R7

   AST_ABORT_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> !mem_wr_valid); // R8

   AST_ABORT_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> !tx_active); // R11

   AST_EXPLICIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_run && tx_abort_req) |=> (abort_pulse && abort_cause == 2'd0)); // R12

   AST_ONE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |=> !abort_pulse); // R12
endmodule

bind txn_conflict_tracker tct_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_abort_req (tx_abort_req),
   .in_run       (run),
   .commit_pulse (commit_pulse),
   .abort_pulse  (abort_pulse),
   .abort_cause  (abort_cause),
   .mem_wr_valid (mem_wr_valid),
   .tx_active    (tx_active)
);

// File: tb/txn_conflict_tracker_tb_top.sv
`timescale 1ns/1ps
module txn_conflict_tracker_tb_top;
   localparam int AW = 12;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_begin = 0, tx_end = 0, tx_abort_req = 0;
   logic ld_valid = 0, st_valid = 0, snp_valid = 0, snp_is_write = 0, evict_valid = 0;
   logic [AW-1:0] ld_addr = '0, st_addr = '0, snp_addr = '0, evict_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic commit_pulse, abort_pulse, mem_wr_valid, tx_active;
   logic [1:0] abort_cause;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #2 clk = ~clk;

   txn_conflict_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_end(tx_end),
      .tx_abort_req(tx_abort_req), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
      .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_is_write(snp_is_write),
      .evict_valid(evict_valid), .evict_addr(evict_addr),
      .commit_pulse(commit_pulse), .abort_pulse(abort_pulse), .abort_cause(abort_cause),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .tx_active(tx_active)
   );

   // Vector layout: [26] store access, [25] snoop is write, [24] abort expected,
   // [23:12] access address, [11:0] snoop address.
   localparam logic [26:0] VEC [8] = '{
      {1'b0, 1'b0, 1'b0, 12'h010, 12'h011},  // R3 read on loaded line
      {1'b0, 1'b1, 1'b1, 12'h010, 12'h013},  // R4 R6 write, other word same line
      {1'b1, 1'b0, 1'b1, 12'h020, 12'h022},  // R5 R6 read on stored line
      {1'b1, 1'b1, 1'b1, 12'h020, 12'h020},  // R5 write on stored line
      {1'b0, 1'b1, 1'b0, 12'h030, 12'h034},  // R6 neighbour line
      {1'b1, 1'b0, 1'b0, 12'h040, 12'h044},  // R6 neighbour line
      {1'b1, 1'b1, 1'b0, 12'h050, 12'h04F},  // R6 neighbour line below
      {1'b0, 1'b0, 1'b0, 12'h060, 12'h060}   // R3 same word read
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_begin();
      tx_begin = 1; tick(); tx_begin = 0;
   endtask
   task automatic do_end();
      tx_end = 1; tick(); tx_end = 0;
   endtask
   task automatic do_ld(input logic [AW-1:0] a);
      ld_valid = 1; ld_addr = a; tick(); ld_valid = 0;
   endtask
   task automatic do_st(input logic [AW-1:0] a, input logic [DW-1:0] d);
      st_valid = 1; st_addr = a; st_data = d; tick(); st_valid = 0;
   endtask
   task automatic do_snp(input logic [AW-1:0] a, input logic w);
      snp_valid = 1; snp_addr = a; snp_is_write = w; tick(); snp_valid = 0;
   endtask
   task automatic do_ev(input logic [AW-1:0] a);
      evict_valid = 1; evict_addr = a; tick(); evict_valid = 0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) tick();
      // R1 reset state
      chk("R1 active", tx_active, 0);
      chk("R1 pulses", {commit_pulse, abort_pulse}, 0);
      chk("R1 mem", mem_wr_valid, 0);
      rst_n = 1;
      tick();

      // Table of snoop scenarios: R3 R4 R5 R6
      for (int v = 0; v < 8; v++) begin
         logic is_st, sw, ex;
         {is_st, sw, ex} = VEC[v][26:24];
         do_begin();
         if (is_st) do_st(VEC[v][23:12], 16'(v));
         else       do_ld(VEC[v][23:12]);
         do_snp(VEC[v][11:0], sw);
         chk($sformatf("R4 R5 R6 vec%0d abort", v), abort_pulse, ex);
         if (ex) begin
            chk($sformatf("R4 vec%0d cause", v), abort_cause, 1);
            chk($sformatf("R4 vec%0d inactive", v), tx_active, 0);
         end else begin
            do_end();
            chk($sformatf("R3 vec%0d commit", v), commit_pulse, 1);
            chk($sformatf("R7 vec%0d drain", v), mem_wr_valid, is_st);
            tick();
            chk($sformatf("R7 vec%0d done", v), tx_active, 0);
         end
         tick();
      end

      // R2 R7 nested commit and ordered drain
      do_begin();
      chk("R2 active", tx_active, 1);
      do_st(12'h100, 16'hA001);
      do_st(12'h205, 16'hA002);
      do_begin();
      do_st(12'h300, 16'hA003);
      do_end();
      chk("R2 inner end no commit", commit_pulse, 0);
      chk("R7 no early write", mem_wr_valid, 0);
      do_end();
      chk("R2 commit", commit_pulse, 1);
      chk("R7 w0", {mem_wr_valid, 3'b0, mem_wr_addr, mem_wr_data}, {1'b1, 3'b0, 12'h100, 16'hA001});
      tick();
      chk("R7 w1", {mem_wr_valid, 3'b0, mem_wr_addr, mem_wr_data}, {1'b1, 3'b0, 12'h205, 16'hA002});
      chk("R2 single pulse", commit_pulse, 0);
      tick();
      chk("R7 w2", {mem_wr_valid, 3'b0, mem_wr_addr, mem_wr_data}, {1'b1, 3'b0, 12'h300, 16'hA003});
      chk("R7 active in drain", tx_active, 1);
      tick();
      chk("R7 drain end", {mem_wr_valid, tx_active}, 0);

      // R13 marks cleared after drain
      do_begin();
      do_snp(12'h205, 1);
      do_snp(12'h100, 1);
      chk("R13 no abort", abort_pulse, 0);
      do_end();
      chk("R13 commit", commit_pulse, 1);
      tick();

      // R12 R8 explicit abort with same-cycle conflict
      do_begin();
      do_st(12'h050, 16'hBEEF);
      tx_abort_req = 1; snp_valid = 1; snp_addr = 12'h050; snp_is_write = 1;
      tick();
      tx_abort_req = 0; snp_valid = 0;
      chk("R12 abort", abort_pulse, 1);
      chk("R12 cause", abort_cause, 0);
      chk("R8 no write", mem_wr_valid, 0);
      tick();
      chk("R12 one pulse", abort_pulse, 0);
      chk("R8 still no write", {mem_wr_valid, tx_active}, 0);

      // R9 eviction
      do_begin();
      do_ld(12'h060);
      do_ev(12'h070);
      chk("R9 untracked ignored", {abort_pulse, tx_active}, 2'b01);
      do_ev(12'h061);
      chk("R9 abort", abort_pulse, 1);
      chk("R9 cause", abort_cause, 2);
      tick();

      // R10 table capacity
      do_begin();
      do_ld(12'h000); do_ld(12'h004); do_ld(12'h008); do_ld(12'h00C);
      do_ld(12'h001);
      chk("R10 hit in full table", {abort_pulse, tx_active}, 2'b01);
      do_ld(12'h010);
      chk("R10 table abort", abort_pulse, 1);
      chk("R10 table cause", abort_cause, 2);
      tick();

      // R10 store buffer capacity
      do_begin();
      for (int k = 0; k < 4; k++) do_st(12'h080 + 12'(k), 16'(k));
      chk("R10 buffer full ok", {abort_pulse, tx_active}, 2'b01);
      do_st(12'h081, 16'h5555);
      chk("R10 buffer abort", abort_pulse, 1);
      chk("R10 buffer cause", abort_cause, 2);
      chk("R8 buffer discard", mem_wr_valid, 0);
      tick();

      // R11 nesting overflow then fresh start
      do_begin(); do_begin(); do_begin();
      chk("R11 depth limit ok", {abort_pulse, tx_active}, 2'b01);
      do_begin();
      chk("R11 nest abort", abort_pulse, 1);
      chk("R11 nest cause", abort_cause, 3);
      tick();
      do_begin();
      do_end();
      chk("R11 fresh commit", commit_pulse, 1);
      tick();

      summary();
   end
endmodule